// File: doc/BRIEF.md
# Programmable Start/Stop Offset Counter

This block is a synchronous up-counter that runs over a window of values picked at run time rather than over the whole binary range. Two inputs set the window. One is the value the counter returns to. The other is the value at which it wraps. Both are read live each cycle, so the window can be moved while the counter runs.

An equality comparator watches for the wrap value. While counting is enabled, it raises a terminal flag during the cycle in which the count equals that value. On the next rising edge the counter takes the return value through a synchronous parallel load. A separate all-ones output lets a higher-order stage chain off this one. A synchronous clear returns the count to zero.

Control and datapath are separate modules. The control module decides each cycle whether to clear, load or increment. It passes that decision to the datapath register as a small set of strobes.

Top module: `offsetCounter`

## Requirements
- R1: When clearIn is high at a rising edge, countOut becomes 0000 after that edge, whether enableIn is high or low.
- R2: When clearIn is low and enableIn is low at a rising edge, countOut keeps its value.
- R3: When clearIn is low, enableIn is high and countOut differs from endVal, countOut increases by one at the rising edge.
- R4: When clearIn is low, enableIn is high and countOut equals endVal, countOut takes the value of startVal present at that rising edge.
- R5: terminalOut is high in a cycle exactly when enableIn is high and countOut equals endVal. It follows these inputs in the same cycle, without waiting for a clock edge.
- R6: rippleCarryOut is high exactly when countOut is 1111, whatever the state of enableIn or endVal.
- R7: If startVal is greater than endVal, the counter counts up from startVal through 1111, wraps to 0000, and keeps counting up until it reaches endVal. No range check is made.
- R8: If startVal equals endVal and enable is high, the counter stays on that value with terminalOut high on every cycle.
- R9: Clear takes priority over the reload. With clearIn high while countOut equals endVal and enable is high, the next count is 0000, not startVal.
- R10: A change to endVal or startVal while the counter is running takes effect at once. The comparison uses the current endVal, and the load uses startVal as it is at the reload edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| clearIn | input | 1 | Synchronous clear to zero, highest priority |
| enableIn | input | 1 | Count enable |
| startVal | input | WIDTH | Value loaded after the wrap point |
| endVal | input | WIDTH | Wrap point compared against the count |
| countOut | output | WIDTH | Current count |
| terminalOut | output | 1 | High while enabled at the wrap point |
| rippleCarryOut | output | 1 | High when the count is all ones |

## Verification
The bench goes after five corner cases; each one catches a different kind of wrong design.
- **Equal start and stop values.** A design that increments before comparing would drift away from the value instead of reloading it.
- **Start value above the stop value.** The count has to pass through 1111 and wrap to 0000. A design that saturates would stop there, and one that range-checks would load early.
- **Clear arriving at the wrap point.** A design with the wrong priority would load the start value instead of zero.
- **Moving the stop value mid-run.** A design that latched the stop value earlier would wrap at the old point.
- **Ripple carry with enable low.** A design that gated the all-ones flag with enable would drop the flag while the counter is held at 1111.

// File: rtl/counterPkg.sv
package counterPkg;
  typedef struct packed {
    logic clr;
    logic load;
    logic inc;
  } ctlStrobe_t;
endpackage

// File: rtl/offsetCounterCtl.sv
module offsetCounterCtl
  import counterPkg::*;
#(
  parameter int WIDTH = 4
) (
  input  logic             clk,
  input  logic             clearIn,
  input  logic             enableIn,
  input  logic [WIDTH-1:0] countIn,
  input  logic [WIDTH-1:0] endVal,
  output ctlStrobe_t       strobeOut,
  output logic             terminalOut
);
  logic atEnd;

  // Equality comparator against the run-time wrap point
  assign atEnd = (countIn == endVal);
  assign terminalOut = enableIn && atEnd;

  // Priority: clear, then reload at the wrap point, then step, else hold
  always_comb begin
    strobeOut = '0;
    if (clearIn)            strobeOut.clr  = 1'b1;
    else if (terminalOut)   strobeOut.load = 1'b1;
    else if (enableIn)      strobeOut.inc  = 1'b1;
  end

  logic armed = 1'b0;
  always_ff @(posedge clk) if (clearIn) armed <= 1'b1;

  // R9: never more than one action per cycle
  assert_one_action_R9: assert property (@(posedge clk) disable iff (!armed)
    $onehot0({strobeOut.clr, strobeOut.load, strobeOut.inc}));
  // R5: terminal flag only while enabled
  assert_terminal_enabled_R5: assert property (@(posedge clk) disable iff (!armed)
    terminalOut |-> enableIn);
  // R2: enable low and no clear means no strobe
  assert_idle_no_strobe_R2: assert property (@(posedge clk) disable iff (!armed)
    (!enableIn && !clearIn) |-> (strobeOut == '0));
endmodule

// File: rtl/offsetCounterPath.sv
module offsetCounterPath
  import counterPkg::*;
#(
  parameter int WIDTH = 4
) (
  input  logic             clk,
  input  ctlStrobe_t       strobeIn,
  input  logic [WIDTH-1:0] startVal,
  output logic [WIDTH-1:0] countOut,
  output logic             rippleCarryOut
);
  localparam logic [WIDTH-1:0] ALL_ONES = {WIDTH{1'b1}};
  localparam logic [WIDTH-1:0] ONE      = {{(WIDTH-1){1'b0}}, 1'b1};

  logic [WIDTH-1:0] countReg;

  always_ff @(posedge clk) begin
    if (strobeIn.clr)       countReg <= '0;
    else if (strobeIn.load) countReg <= startVal;
    else if (strobeIn.inc)  countReg <= countReg + ONE;
  end

  assign countOut       = countReg;
  assign rippleCarryOut = (countReg == ALL_ONES);

  logic armed = 1'b0;
  always_ff @(posedge clk) if (strobeIn.clr) armed <= 1'b1;

  // R1: clear lands on zero
  assert_clear_zero_R1: assert property (@(posedge clk) disable iff (!armed)
    strobeIn.clr |=> (countOut == '0));
  // R4: reload takes the start value present at the edge
  assert_reload_start_R4: assert property (@(posedge clk) disable iff (!armed)
    strobeIn.load |=> (countOut == $past(startVal)));
  // R3: step is exactly one, wrapping modulo 2^WIDTH (R7)
  assert_step_one_R3: assert property (@(posedge clk) disable iff (!armed)
    strobeIn.inc |=> (countOut == $past(countOut) + ONE));
  // R2: no strobe holds the count
  assert_hold_R2: assert property (@(posedge clk) disable iff (!armed)
    (strobeIn == '0) |=> $stable(countOut));
endmodule

// File: rtl/offsetCounter.sv
module offsetCounter
  import counterPkg::*;
#(
  parameter int WIDTH = 4
) (
  input  logic             clk,
  input  logic             clearIn,
  input  logic             enableIn,
  input  logic [WIDTH-1:0] startVal,
  input  logic [WIDTH-1:0] endVal,
  output logic [WIDTH-1:0] countOut,
  output logic             terminalOut,
  output logic             rippleCarryOut
);
  ctlStrobe_t       strobe;
  logic [WIDTH-1:0] countNow;

  offsetCounterCtl #(.WIDTH(WIDTH)) u_ctl (
    .clk         (clk),
    .clearIn     (clearIn),
    .enableIn    (enableIn),
    .countIn     (countNow),
    .endVal      (endVal),
    .strobeOut   (strobe),
    .terminalOut (terminalOut)
  );

  offsetCounterPath #(.WIDTH(WIDTH)) u_path (
    .clk            (clk),
    .strobeIn       (strobe),
    .startVal       (startVal),
    .countOut       (countNow),
    .rippleCarryOut (rippleCarryOut)
  );

  assign countOut = countNow;
endmodule

// File: tb/offsetCounter_tb.sv
module offsetCounter_tb;
  logic       clk = 1'b0;
  logic       clearIn = 1'b0;
  logic       enableIn = 1'b0;
  logic [3:0] startVal = '0;
  logic [3:0] endVal = '0;
  logic [3:0] countOut;
  logic       terminalOut, rippleCarryOut;

  int errors = 0;
  int checks = 0;
  logic [3:0] model = '0;

  always #5 clk = ~clk;

  offsetCounter #(.WIDTH(4)) u_dut (
    .clk(clk), .clearIn(clearIn), .enableIn(enableIn),
    .startVal(startVal), .endVal(endVal), .countOut(countOut),
    .terminalOut(terminalOut), .rippleCarryOut(rippleCarryOut)
  );

  // {start, end, cycles}
  localparam logic [15:0] SCEN [6] = '{
    {4'd6,  4'd15, 8'd24},
    {4'd0,  4'd13, 8'd30},
    {4'd3,  4'd9,  8'd20},
    {4'd5,  4'd5,  8'd6},
    {4'd12, 4'd2,  8'd30},
    {4'd0,  4'd15, 8'd34}
  };

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Called just after a negedge: apply inputs, check combinational flags,
  // let one rising edge pass, then check the count at the next negedge.
  task automatic step(logic clr, logic en, string req);
    logic [3:0] nxt;
    clearIn = clr;
    enableIn = en;
    #1;
    check("R5", terminalOut, (en && model == endVal) ? 1 : 0);
    check("R6", rippleCarryOut, (model == 4'hF) ? 1 : 0);
    if (clr)                       nxt = 4'h0;
    else if (en && model == endVal) nxt = startVal;
    else if (en)                   nxt = model + 4'h1;
    else                           nxt = model;
    @(negedge clk);
    model = nxt;
    check(req, countOut, model);
  endtask

  function automatic string tagFor(logic [3:0] c, logic [3:0] s, logic [3:0] e);
    if (c == e) return (s == e) ? "R8" : "R4";
    if (c == 4'hF) return "R7";
    return "R3";
  endfunction

  initial begin
    #2000000;
    errors++;
    $display("FAIL watchdog: actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    @(negedge clk);
    // R1: reset state via synchronous clear
    step(1'b1, 1'b0, "R1");

    for (int i = 0; i < 6; i++) begin
      startVal = SCEN[i][15:12];
      endVal   = SCEN[i][11:8];
      step(1'b1, 1'b1, "R1");
      for (int k = 0; k < int'(SCEN[i][7:0]); k++)
        step(1'b0, 1'b1, tagFor(model, startVal, endVal));
    end

    // R2: hold with enable low, including at the wrap point
    startVal = 4'd2; endVal = 4'd7;
    step(1'b1, 1'b0, "R1");
    for (int k = 0; k < 7; k++) step(1'b0, 1'b1, "R3");
    for (int k = 0; k < 3; k++) step(1'b0, 1'b0, "R2");
    step(1'b0, 1'b1, "R4");

    // R9: clear at the wrap point wins over reload
    for (int k = 0; k < 5; k++) step(1'b0, 1'b1, "R3");
    step(1'b1, 1'b1, "R9");

    // R6: all-ones flag while held with enable low
    endVal = 4'd15;
    for (int k = 0; k < 15; k++) step(1'b0, 1'b1, "R3");
    step(1'b0, 1'b0, "R6");
    step(1'b0, 1'b0, "R6");

    // R10: move the wrap point and start value mid-run
    step(1'b1, 1'b1, "R1");
    for (int k = 0; k < 3; k++) step(1'b0, 1'b1, "R3");
    endVal = 4'd4;
    step(1'b0, 1'b1, "R10");
    startVal = 4'd9;
    step(1'b0, 1'b1, "R10");
    step(1'b0, 1'b1, "R10");

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule